// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold DMA Requests

This block is a word-organised sample buffer that sits between a DMA engine and a serial audio port. Each entry holds one sample, so the sample width chosen for a stream never changes how many entries fit. Depth and entry width are parameters. Typical depths are 128 and 1280 words.

The DMA request output tells the DMA engine when to act. A direction input selects between transmit use and receive use. In transmit use, the DMA engine fills the buffer and the serial port drains it. The request is raised while the number of free entries is at least the transmit threshold. In receive use, the serial port fills the buffer and the DMA engine empties it. The request is raised while the number of stored entries is at least the receive threshold. Each direction has its own threshold input, counted in words.

The block also reports its latency in whole frames: the number of stored words divided by the channel count, with any partial frame dropped. A write to a full buffer and a read from an empty one are both refused. Each sets a sticky flag, and an empty read returns zero.

Top module: `smpl_fifo_dreq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `level` 0, `frames` 0, `rd_data` 0, and both `ovf_flag` and `unf_flag` 0.
- R2: Words leave in the order they were written. The word for a read accepted on one clock edge appears on `rd_data` after that edge and holds until the next read.
- R3: A write while the buffer holds DEPTH words is dropped and leaves `level` at DEPTH. It sets `ovf_flag`, which stays 1 until reset.
- R4: A read while `level` is 0 loads 0 into `rd_data` and sets `unf_flag`, which stays 1 until reset.
- R5: The buffer holds exactly DEPTH words. DEPTH writes from empty give `level` = DEPTH, and all DEPTH words read back intact.
- R6: With `dir_rx` = 0 (transmit), `dma_req` is 1 exactly when DEPTH − `level` ≥ the effective transmit threshold.
- R7: With `dir_rx` = 1 (receive), `dma_req` is 1 exactly when `level` ≥ the effective receive threshold.
- R8: A threshold input of 0 acts as 1. A threshold input above DEPTH acts as DEPTH.
- R9: `frames` equals floor(`level` / effective channel count) and follows `level` in the same cycle.
- R10: A `chan_cnt` of 0 acts as 1 channel. A `chan_cnt` above 16 acts as 16 channels.
- R11: A read and a write on the same edge, with the buffer neither empty nor full, leave `level` unchanged. If the buffer is empty, the read underflows and the write is still stored.
- R12: Only the threshold of the selected direction affects `dma_req`. Changing the other threshold leaves `dma_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_rx | input | 1 | 0 = transmit use, 1 = receive use |
| tx_thresh | input | $clog2(DEPTH+1) | Transmit threshold in words |
| rx_thresh | input | $clog2(DEPTH+1) | Receive threshold in words |
| chan_cnt | input | 5 | Channels per frame (0 acts as 1, above 16 acts as 16) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Sample to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Sample read, registered |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| frames | output | $clog2(DEPTH+1) | Stored whole frames (latency) |
| dma_req | output | 1 | DMA request |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The bench fills the buffer to the last entry and then writes one more word. A design that wrapped its write pointer would corrupt the oldest sample, and a count that rolled over would report an empty buffer. Thresholds are stepped across the exact words where the request should toggle, including 0 and values above DEPTH. A missing clamp shows up as a request that never rises or is stuck high. The channel count is driven to 0 and above 16, where a divider without a guard would return a garbage frame count. Simultaneous read and write are exercised on an empty buffer to catch a design that forwards the incoming word instead of reporting underflow.

// File: rtl/sfd_pkg.sv
// Shared definitions for the sample FIFO with DMA requests.
// Assumes: channel counts are carried on a 5-bit field.
package sfd_pkg;
    // Width of the channel-count field and the largest legal count
    localparam int CH_W     = 5;
    localparam int CH_LIMIT = 16;

    // Direction of use selected by the dir_rx pin
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } sfd_dir_e;
endpackage

// File: rtl/sfd_store.sv
// Word store with wrap-around pointers, occupancy counter and sticky error flags.
// A write while full is dropped; a read while empty loads zero into rd_data.
// Assumes: DEPTH >= 2; DEPTH need not be a power of two.
module sfd_store #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] level,
    output logic             ovf_flag,
    output logic             unf_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             is_full;
    logic             is_empty;
    logic             wr_ok;
    logic             rd_ok;

    // Next pointer value with wrap at the last entry
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Accept decisions for this cycle
    always_comb begin
        is_full  = (level == FULL_CNT);
        is_empty = (level == '0);
        wr_ok    = wr_en && !is_full;
        rd_ok    = rd_en && !is_empty;
    end

    // Sample storage, no reset needed
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Write and read pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
        end
    end

    // Registered read data, zero on an empty read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= mem[rd_ptr];
        end else if (rd_en) begin
            rd_data <= '0;
        end
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (wr_en && is_full)  ovf_flag <= 1'b1;
            if (rd_en && is_empty) unf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/sfd_req_gen.sv
// DMA request generator: clamps both thresholds to 1..DEPTH and compares the
// selected one with free space (transmit) or occupancy (receive).
// Assumes: level never exceeds DEPTH.
module sfd_req_gen
    import sfd_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sfd_dir_e         dir,
    input  logic [CNT_W-1:0] tx_thresh,
    input  logic [CNT_W-1:0] rx_thresh,
    input  logic [CNT_W-1:0] level,
    output logic             dma_req
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] thr_raw [2];
    logic [CNT_W-1:0] thr_eff [2];
    logic [CNT_W-1:0] free_cnt;

    assign thr_raw[0] = tx_thresh;
    assign thr_raw[1] = rx_thresh;

    // One clamp per direction
    for (genvar d = 0; d < 2; d++) begin : g_clamp
        // Force the threshold into 1..DEPTH
        always_comb begin
            if (thr_raw[d] == '0) begin
                thr_eff[d] = CNT_W'(1);
            end else if (thr_raw[d] > FULL_CNT) begin
                thr_eff[d] = FULL_CNT;
            end else begin
                thr_eff[d] = thr_raw[d];
            end
        end
    end

    // Compare the selected threshold against free or stored words
    always_comb begin
        free_cnt = FULL_CNT - level;
        if (dir == DIR_RX) begin
            dma_req = (level >= thr_eff[1]);
        end else begin
            dma_req = (free_cnt >= thr_eff[0]);
        end
    end
endmodule

// File: rtl/sfd_frame_div.sv
// Whole-frame latency: divides the word count by the clamped channel count
// with an unrolled restoring divider; the remainder is discarded.
// Assumes: the divisor after clamping lies in 1..CH_LIMIT.
module sfd_frame_div
    import sfd_pkg::*;
#(
    parameter int NUM_W = 8
) (
    input  logic [NUM_W-1:0] words,
    input  logic [CH_W-1:0]  chan_cnt,
    output logic [NUM_W-1:0] frames
);
    localparam int RW = CH_W + 1;

    logic [CH_W-1:0] den;
    logic [RW-1:0]   rem [NUM_W+1];

    // Clamp the channel count into 1..CH_LIMIT
    always_comb begin
        if (chan_cnt == '0) begin
            den = CH_W'(1);
        end else if (chan_cnt > CH_W'(CH_LIMIT)) begin
            den = CH_W'(CH_LIMIT);
        end else begin
            den = chan_cnt;
        end
    end

    assign rem[0] = '0;

    // One restoring stage per quotient bit, most significant first
    for (genvar i = 0; i < NUM_W; i++) begin : g_stage
        logic [RW-1:0] trial;
        logic          take;
        assign trial = {rem[i][CH_W-1:0], words[NUM_W-1-i]};
        assign take  = (trial >= {1'b0, den});
        assign rem[i+1] = take ? (trial - {1'b0, den}) : trial;
        assign frames[NUM_W-1-i] = take;
    end
endmodule

// File: rtl/smpl_fifo_dreq.sv
// Top level: sample FIFO with threshold-driven DMA request and frame latency.
// Assumes: one clock domain shared by DMA side and serial-port side.
module smpl_fifo_dreq
    import sfd_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_rx,
    input  logic [CNT_W-1:0] tx_thresh,
    input  logic [CNT_W-1:0] rx_thresh,
    input  logic [CH_W-1:0]  chan_cnt,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] frames,
    output logic             dma_req,
    output logic             ovf_flag,
    output logic             unf_flag
);
    sfd_dir_e dir_sel;

    // Map the direction pin onto the enum
    always_comb begin
        dir_sel = dir_rx ? DIR_RX : DIR_TX;
    end

    sfd_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .level    (level),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    sfd_req_gen #(.DEPTH(DEPTH)) req_i (
        .dir       (dir_sel),
        .tx_thresh (tx_thresh),
        .rx_thresh (rx_thresh),
        .level     (level),
        .dma_req   (dma_req)
    );

    sfd_frame_div #(.NUM_W(CNT_W)) div_i (
        .words    (level),
        .chan_cnt (chan_cnt),
        .frames   (frames)
    );
endmodule

// File: rtl/sfd_chk.sv
// Property checker for smpl_fifo_dreq, attached by bind below.
// Assumes: connected to the top-level ports only.
module sfd_chk #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_rx,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [CNT_W-1:0] level,
    input logic [CNT_W-1:0] frames,
    input logic             dma_req,
    input logic             ovf_flag,
    input logic             unf_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && level == FULL_CNT) |=> (level == FULL_CNT && ovf_flag));

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == '0) |=> (rd_data == '0 && unf_flag));

    p_unf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    p_tx_full_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && level == FULL_CNT) |-> !dma_req);

    p_rx_empty_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rx && level == '0) |-> !dma_req);

    p_frames_le_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= level);

    p_simul_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && level != '0 && level != FULL_CNT) |=> (level == $past(level)));
endmodule

bind smpl_fifo_dreq sfd_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_rx   (dir_rx),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .level    (level),
    .frames   (frames),
    .dma_req  (dma_req),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
);

// File: tb/smpl_fifo_dreq_tb_top.sv
module smpl_fifo_dreq_tb_top;
    localparam int DEPTH = 128;
    localparam int WIDTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dir_rx = 1'b0;
    logic [CNT_W-1:0] tx_thresh = '0;
    logic [CNT_W-1:0] rx_thresh = '0;
    logic [4:0]       chan_cnt = 5'd1;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] frames;
    logic             dma_req;
    logic             ovf_flag;
    logic             unf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smpl_fifo_dreq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .chan_cnt(chan_cnt),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .level(level), .frames(frames), .dma_req(dma_req),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) push(32'(1000 + i));
    endtask

    task automatic t_reset();
        dir_rx = 1'b0; tx_thresh = CNT_W'(1); rx_thresh = CNT_W'(1); chan_cnt = 5'd1;
        do_reset();
        chk("R1", "level", level, 0);
        chk("R1", "frames", frames, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "ovf", ovf_flag, 0);
        chk("R1", "unf", unf_flag, 0);
    endtask

    task automatic t_order();
        do_reset();
        push(32'd10); push(32'd20); push(32'd30);
        pop(); chk("R2", "first word", rd_data, 10);
        push(32'd40);
        pop(); chk("R2", "second word", rd_data, 20);
        @(negedge clk);
        chk("R2", "data held", rd_data, 20);
        pop(); chk("R2", "third word", rd_data, 30);
        pop(); chk("R2", "fourth word", rd_data, 40);
        chk("R2", "level drained", level, 0);
    endtask

    task automatic t_full();
        int bad_words;
        do_reset();
        dir_rx = 1'b0; tx_thresh = CNT_W'(1);
        for (int i = 0; i < DEPTH; i++) push(32'(i * 7 + 3));
        chk("R5", "level full", level, DEPTH);
        chk("R6", "tx req at full", dma_req, 0);
        push(32'hDEAD);
        chk("R3", "level after drop", level, DEPTH);
        chk("R3", "ovf set", ovf_flag, 1);
        bad_words = 0;
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            if (rd_data != 32'(i * 7 + 3)) bad_words++;
        end
        chk("R5", "words intact", bad_words, 0);
        chk("R3", "ovf sticky", ovf_flag, 1);
        pop();
        chk("R4", "empty read data", rd_data, 0);
        chk("R4", "unf set", unf_flag, 1);
        chk("R4", "level stays 0", level, 0);
        repeat (3) @(negedge clk);
        chk("R4", "unf sticky", unf_flag, 1);
        do_reset();
        chk("R1", "ovf cleared", ovf_flag, 0);
        chk("R1", "unf cleared", unf_flag, 0);
    endtask

    task automatic t_req();
        do_reset();
        dir_rx = 1'b0; tx_thresh = CNT_W'(100); rx_thresh = CNT_W'(5);
        @(negedge clk);
        chk("R6", "tx req empty", dma_req, 1);
        fill(28);
        chk("R6", "tx req free=100", dma_req, 1);
        fill(1);
        chk("R6", "tx req free=99", dma_req, 0);
        dir_rx = 1'b1;
        @(negedge clk);
        chk("R7", "rx req 29>=5", dma_req, 1);
        rx_thresh = CNT_W'(29);
        @(negedge clk);
        chk("R7", "rx req 29>=29", dma_req, 1);
        rx_thresh = CNT_W'(30);
        @(negedge clk);
        chk("R7", "rx req 29<30", dma_req, 0);
        tx_thresh = CNT_W'(0);
        @(negedge clk);
        chk("R12", "tx thr ignored in rx", dma_req, 0);
        rx_thresh = CNT_W'(1); dir_rx = 1'b0; tx_thresh = CNT_W'(100);
        @(negedge clk);
        chk("R12", "rx thr ignored in tx", dma_req, 0);
    endtask

    task automatic t_clamp();
        do_reset();
        dir_rx = 1'b1; rx_thresh = CNT_W'(0);
        @(negedge clk);
        chk("R8", "rx thr 0 empty", dma_req, 0);
        push(32'd1);
        chk("R8", "rx thr 0 one word", dma_req, 1);
        rx_thresh = CNT_W'(200);
        fill(DEPTH - 2);
        chk("R8", "rx thr 200 at 127", dma_req, 0);
        push(32'd2);
        chk("R8", "rx thr 200 at full", dma_req, 1);
        do_reset();
        dir_rx = 1'b0; tx_thresh = CNT_W'(255);
        @(negedge clk);
        chk("R8", "tx thr 255 empty", dma_req, 1);
        push(32'd3);
        chk("R8", "tx thr 255 one word", dma_req, 0);
    endtask

    task automatic t_frames();
        do_reset();
        fill(29);
        chan_cnt = 5'd2; @(negedge clk); chk("R9", "29/2", frames, 14);
        chan_cnt = 5'd3; @(negedge clk); chk("R9", "29/3", frames, 9);
        chan_cnt = 5'd16; @(negedge clk); chk("R9", "29/16", frames, 1);
        chan_cnt = 5'd0; @(negedge clk); chk("R10", "29/0 as 1", frames, 29);
        fill(71);
        chan_cnt = 5'd7; @(negedge clk); chk("R9", "100/7", frames, 14);
        chan_cnt = 5'd20; @(negedge clk); chk("R10", "100/20 as 16", frames, 6);
        chan_cnt = 5'd31; @(negedge clk); chk("R10", "100/31 as 16", frames, 6);
        chan_cnt = 5'd4; @(negedge clk);
        push(32'd9);
        chk("R9", "101/4 after write", frames, 25);
        chan_cnt = 5'd1;
    endtask

    task automatic t_simul();
        do_reset();
        push(32'd5); push(32'd6);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd7; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11", "level held", level, 2);
        chk("R11", "head read", rd_data, 5);
        pop(); chk("R11", "next word", rd_data, 6);
        pop(); chk("R11", "written word", rd_data, 7);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd8; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11", "empty simul data", rd_data, 0);
        chk("R11", "empty simul unf", unf_flag, 1);
        chk("R11", "empty simul level", level, 1);
        pop(); chk("R11", "stored after simul", rd_data, 8);
    endtask

    initial begin
        t_reset();
        t_order();
        t_full();
        t_req();
        t_clamp();
        t_frames();
        t_simul();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule